// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank DDR SDRAM. It accepts one read or write request at a time, each with a bank, a row, a starting column, a burst-length code and an auto-precharge flag. It turns the request into a legal series of device commands. A request to a bank with no open row gets a row activation and then the column access. A request that hits the open row goes straight to the column access. A request that misses the open row first closes the bank, then activates the new row, then performs the access.

Each bank keeps its own open-row record and its own down-counter for the activation-to-access and precharge-to-activation gaps, so one bank can finish a precharge while another bank is activated. After a column access the sequencer keeps the command bus quiet for the burst, which lasts half as many clocks as the burst has words. When auto precharge is requested, the bank is marked closed and stays blocked until the burst has finished and the precharge time has run out. Commands, bank and address leave the block from registers, at most one command per clock.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset, cmd_out is NOP (000), req_ready is 1 and every bank is closed, so the first request to any bank begins with an activation and no precharge.
- R2: A request to a closed bank issues an activation (001) with the row on cmd_addr, then the column access exactly T_RCD cycles after the activation.
- R3: A request whose row equals the bank's open row issues the column access as its first command, with no activation or precharge.
- R4: A request whose row differs from the bank's open row issues a precharge (100) with cmd_addr zero, an activation exactly T_RP cycles later, and the access exactly T_RCD cycles after that.
- R5: req_blen, sampled when a request is accepted, selects the burst length: 00 gives 2, 01 gives 4, 10 and 11 give 8. No command is issued in the BL/2 cycles that start with a column access. Consecutive row-hit accesses are exactly BL/2+2 cycles apart, where BL belongs to the earlier access.
- R6: An access with req_autopre set drives cmd_ap high with the access and leaves the bank closed, so the next request to that bank starts with an activation and no precharge. That activation comes exactly BL/2+T_RP cycles after the access when the request is already waiting.
- R7: A request is accepted in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the command series and its burst have ended. A request held valid during that time is taken afterwards and is not lost.
- R8: Banks are independent. An open row in one bank survives activity in another bank, and a closed bank can be activated while a different bank is still waiting out its auto-precharge time.
- R9: Command codes are NOP 000, activate 001, read 010, write 011, precharge 100. req_write selects write over read. The column access carries the column zero-extended on cmd_addr. Every command carries its bank on cmd_bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released in step with clk |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The sequencer can take a request this cycle |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W (13) | Target row |
| req_col | input | COL_W (9) | Starting column of the burst |
| req_blen | input | 2 | Burst-length code: 00 = 2, 01 = 4, 1x = 8 |
| req_autopre | input | 1 | Close the row by itself after the burst |
| cmd_out | output | 3 | Registered command code |
| cmd_bank | output | BANK_W (2) | Bank for the command |
| cmd_addr | output | ADDR_W (13) | Row for activation, column for access, zero for precharge |
| cmd_ap | output | 1 | Auto-precharge flag travelling with a column access |

## Verification
The assertions assume that req_bank, req_row, req_col, req_blen, req_write and req_autopre are stable in a cycle where req_valid is high. They also assume that timing parameters are at least one and that nothing other than this sequencer sends commands to the device, since the bank records follow only its own commands. The bench changes request fields only at the falling clock edge. It holds each request until the handshake completes, and it lets every bank's counters run out between scenarios that depend on exact cycle gaps, so each measured gap is set by one rule alone.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_OPEN,
    ST_ACCESS,
    ST_BURST
  } seq_st_e;

  // Clock cycles a burst occupies on the data pins (two words per clock).
  function automatic logic [2:0] burst_cycles(input logic [1:0] code);
    case (code)
      2'b00:   burst_cycles = 3'd1;
      2'b01:   burst_cycles = 3'd2;
      default: burst_cycles = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int ROW_W = 13,
  parameter int T_RCD = 3,
  parameter int T_RP  = 4,
  parameter int TMR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             acc_i,
  input  logic             ap_i,
  input  logic [2:0]       half_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             idle_o
);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    tmr_d  = tmr_q;
    open_d = open_q;
    if (act_i) begin
      tmr_d  = TMR_W'(T_RCD - 1);
      open_d = 1'b1;
    end else if (pre_i) begin
      tmr_d  = TMR_W'(T_RP - 1);
      open_d = 1'b0;
    end else if (acc_i && ap_i) begin
      tmr_d  = TMR_W'(half_i) + TMR_W'(T_RP - 1);
      open_d = 1'b0;
    end else if (tmr_q != '0) begin
      tmr_d  = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      open_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_q <= '0;
    else if (act_i) row_q <= row_i;
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign idle_o = (tmr_q == '0);

  // Activation only to a closed, settled bank.
  assert_act_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && idle_o));
  // Precharge only to an open, settled bank.
  assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |-> (open_q && idle_o));
  // Column access only to an open, settled bank.
  assert_acc_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> (open_q && idle_o));
  // A bank never receives two operations in one cycle.
  assert_one_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_i, pre_i, acc_i}));
  // Auto precharge closes the bank and blocks it for at least one cycle.
  assert_ap_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && ap_i) |=> (!open_q && !idle_o));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 4,
  parameter int BANK_W = $clog2(NBANK),
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_blen,
  input  logic              req_autopre,
  output logic [2:0]        cmd_out,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ap
);

  localparam int TMR_W = $clog2(T_RCD + T_RP + 8) + 1;

  seq_st_e st_q, st_d;
  logic [2:0] cnt_q, cnt_d;

  // Latched request
  logic              rq_write, rq_ap, ld_req;
  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;
  logic [2:0]        rq_half;

  // Registered command outputs
  cmd_e              cmd_q, cmd_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ap_q, ap_d;

  // Per-bank state
  logic [NBANK-1:0]  act_v, pre_v, acc_v, b_open, b_idle;
  logic [ROW_W-1:0]  b_row [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_bank_track #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .TMR_W(TMR_W)
    ) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act_v[b]),
      .pre_i  (pre_v[b]),
      .acc_i  (acc_v[b]),
      .ap_i   (rq_ap),
      .half_i (rq_half),
      .row_i  (rq_row),
      .open_o (b_open[b]),
      .row_o  (b_row[b]),
      .idle_o (b_idle[b])
    );
  end

  assign req_ready = (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ld_req = 1'b0;
    cmd_d  = CMD_NOP;
    bank_d = '0;
    addr_d = '0;
    ap_d   = 1'b0;
    act_v  = '0;
    pre_v  = '0;
    acc_v  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          if (!b_open[req_bank])                  st_d = ST_OPEN;
          else if (b_row[req_bank] == req_row)    st_d = ST_ACCESS;
          else                                    st_d = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (b_idle[rq_bank]) begin
          cmd_d          = CMD_PRE;
          bank_d         = rq_bank;
          pre_v[rq_bank] = 1'b1;
          st_d           = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (b_idle[rq_bank]) begin
          cmd_d          = CMD_ACT;
          bank_d         = rq_bank;
          addr_d         = ADDR_W'(rq_row);
          act_v[rq_bank] = 1'b1;
          st_d           = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (b_idle[rq_bank]) begin
          cmd_d          = rq_write ? CMD_WR : CMD_RD;
          bank_d         = rq_bank;
          addr_d         = ADDR_W'(rq_col);
          ap_d           = rq_ap;
          acc_v[rq_bank] = 1'b1;
          cnt_d          = rq_half - 1'b1;
          st_d           = ST_BURST;
        end
      end
      ST_BURST: begin
        if (cnt_q == '0) st_d = ST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
      ap_q   <= ap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_write <= 1'b0;
      rq_ap    <= 1'b0;
      rq_bank  <= '0;
      rq_row   <= '0;
      rq_col   <= '0;
      rq_half  <= 3'd1;
    end else if (ld_req) begin
      rq_write <= req_write;
      rq_ap    <= req_autopre;
      rq_bank  <= req_bank;
      rq_row   <= req_row;
      rq_col   <= req_col;
      rq_half  <= burst_cycles(req_blen);
    end
  end

  assign cmd_out  = cmd_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;
  assign cmd_ap   = ap_q;

  // Checker state: cycles of the current burst still to run on the output.
  logic [2:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  quiet_q <= '0;
    else if (cmd_q == CMD_RD || cmd_q == CMD_WR) quiet_q <= rq_half - 1'b1;
    else if (quiet_q != '0)                      quiet_q <= quiet_q - 1'b1;
  end

  assert_burst_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q != '0) |-> (cmd_q == CMD_NOP));
  assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_ap_only_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ap |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));
  assert_pre_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (cmd_addr == '0));

endmodule

// File: tb/ddr_cmd_seq_bench.sv
module ddr_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 3;
  localparam int T_RP  = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_PRE = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_autopre;
  logic [1:0]  req_bank, req_blen;
  logic [12:0] req_row;
  logic [8:0]  req_col;
  logic        req_ready, cmd_ap;
  logic [2:0]  cmd_out;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;

  ddr_cmd_seq #(.NBANK(4), .ROW_W(13), .COL_W(9), .T_RCD(T_RCD), .T_RP(T_RP))
  u_ddr_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_blen(req_blen), .req_autopre(req_autopre),
    .cmd_out(cmd_out), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lg_n = 0;
  int lg_cyc [64];
  int lg_cmd [64];
  int lg_bank [64];
  int lg_addr [64];
  int lg_ap [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cmd_out != C_NOP && lg_n < 64) begin
      lg_cyc[lg_n]  = cyc;
      lg_cmd[lg_n]  = int'(cmd_out);
      lg_bank[lg_n] = int'(cmd_bank);
      lg_addr[lg_n] = int'(cmd_addr);
      lg_ap[lg_n]   = int'(cmd_ap);
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit wr, input int bank, input int row, input int col,
                      input bit ap, input int bl);
    @(negedge clk);
    req_write   = wr;
    req_bank    = 2'(bank);
    req_row     = 13'(row);
    req_col     = 9'(col);
    req_autopre = ap;
    req_blen    = 2'(bl);
    req_valid   = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (24) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cmd_out after reset", int'(cmd_out), int'(C_NOP));
    chk("R1 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_closed_read();
    int b = lg_n;
    send(0, 0, 'h123, 'h45, 0, 1);
    drain();
    chk("R2 command count", lg_n - b, 2);
    chk("R1 first command is activate", lg_cmd[b], int'(C_ACT));
    chk("R2 activate row on address", lg_addr[b], 'h123);
    chk("R9 activate bank", lg_bank[b], 0);
    chk("R9 read code", lg_cmd[b+1], int'(C_RD));
    chk("R9 read column on address", lg_addr[b+1], 'h45);
    chk("R2 activate to read gap", lg_cyc[b+1] - lg_cyc[b], T_RCD);
    chk("R6 no auto precharge flag", lg_ap[b+1], 0);
  endtask

  task automatic t_hits();
    int b = lg_n;
    send(1, 0, 'h123, 'h10, 0, 0);
    send(0, 0, 'h123, 'h11, 0, 1);
    send(0, 0, 'h123, 'h12, 0, 2);
    send(1, 0, 'h123, 'h13, 0, 3);
    drain();
    chk("R3 hit command count", lg_n - b, 4);
    chk("R3 first hit command is write", lg_cmd[b], int'(C_WR));
    chk("R9 write column", lg_addr[b], 'h10);
    chk("R5 gap after BL2", lg_cyc[b+1] - lg_cyc[b], 1 + 2);
    chk("R5 gap after BL4", lg_cyc[b+2] - lg_cyc[b+1], 2 + 2);
    chk("R5 gap after BL8", lg_cyc[b+3] - lg_cyc[b+2], 4 + 2);
    chk("R9 last hit is write", lg_cmd[b+3], int'(C_WR));
  endtask

  task automatic t_miss();
    int b = lg_n;
    send(0, 0, 'h0AA, 3, 0, 1);
    chk("R7 ready low after accept", int'(req_ready), 0);
    @(negedge clk);
    chk("R7 ready low while waiting", int'(req_ready), 0);
    drain();
    chk("R4 miss command count", lg_n - b, 3);
    chk("R4 precharge first", lg_cmd[b], int'(C_PRE));
    chk("R4 precharge address zero", lg_addr[b], 0);
    chk("R4 activate after precharge", lg_cmd[b+1], int'(C_ACT));
    chk("R4 precharge to activate gap", lg_cyc[b+1] - lg_cyc[b], T_RP);
    chk("R4 new row on address", lg_addr[b+1], 'h0AA);
    chk("R4 activate to read gap", lg_cyc[b+2] - lg_cyc[b+1], T_RCD);
  endtask

  task automatic t_banks();
    int b = lg_n;
    send(0, 1, 'h055, 7, 0, 0);
    send(0, 0, 'h0AA, 8, 0, 0);
    drain();
    chk("R8 command count", lg_n - b, 3);
    chk("R8 bank1 activated", lg_cmd[b], int'(C_ACT));
    chk("R9 bank1 on cmd_bank", lg_bank[b], 1);
    chk("R8 bank0 row kept, direct read", lg_cmd[b+2], int'(C_RD));
    chk("R8 bank0 on cmd_bank", lg_bank[b+2], 0);
  endtask

  task automatic t_autopre();
    int b = lg_n;
    send(1, 2, 'h1F0, 9, 1, 0);
    send(1, 3, 'h00F, 1, 0, 0);
    drain();
    chk("R6 count first pair", lg_n - b, 4);
    chk("R6 ap flag on write", lg_ap[b+1], 1);
    chk("R8 other bank activated during ap wait", lg_cmd[b+2], int'(C_ACT));
    chk("R8 overlap gap", lg_cyc[b+2] - lg_cyc[b+1], 3);
    b = lg_n;
    send(0, 2, 'h1F0, 9, 1, 2);
    send(0, 2, 'h1F0, 10, 0, 0);
    drain();
    chk("R6 count second pair", lg_n - b, 4);
    chk("R6 closed bank reopened without precharge", lg_cmd[b], int'(C_ACT));
    chk("R6 ap flag on read", lg_ap[b+1], 1);
    chk("R6 reactivation after ap", lg_cmd[b+2], int'(C_ACT));
    chk("R6 ap to activate gap", lg_cyc[b+2] - lg_cyc[b+1], 4 + T_RP);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_autopre = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; req_blen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_closed_read();
    t_hits();
    t_miss();
    t_banks();
    t_autopre();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule